// File: doc/BRIEF.md
# Match-Capture Counter Timer with PWM

This block is a 32-bit counter/timer with a 32-bit prescaler, one capture channel and four match channels. The timer counter (TC) advances once every PR+1 counting events. In timer mode a counting event is every clock. In counter mode it is a chosen edge of the `cnt_in` pin. Each match channel compares TC with its own match register. On a match it can raise an interrupt flag, stop the timer or restart it from zero, and it can drive its output pin. Channels 0 to 2 can instead produce single-edge PWM. In that case the highest channel is set to reset-on-match, so that its match value fixes the period.

Software reaches the block through a plain register port. A write is taken on the clock edge where `bus_we` is high. A read is a combinational decode of `bus_addr`. The port has no valid/ready pair and no back-pressure: every write is accepted in its cycle and every read answers in the same cycle. The `cap_in` and `cnt_in` pins are asynchronous. Each passes through a two-flop synchronizer before its edge is detected. The interrupt output is level-sensitive.

Top module: `mct_timer`

## Requirements
- R1: The prescale counter (PC, read at address 3) counts each counting event, going from 0 up to the prescale value (PR, address 1). On the event where PC is at least PR, PC returns to 0 and TC (address 2) advances by one. With PR=3 in timer mode, 20 enabled clocks give TC=5 and PC=0. In counter mode with PR=1, six rising edges give TC=3.
- R2: Control register at address 0: bit0 enable, bit1 synchronous reset, bit2 counter mode, bits 4:3 count-edge select, bits 6:5 capture-edge select, bit7 capture interrupt enable. While the reset bit is 1, TC and PC are 0 from the next edge. While enable is 0, TC and PC hold their values.
- R3: In counter mode, TC counts synchronized edges of `cnt_in` as selected by the edge code: 00 none, 01 rising, 10 falling, 11 both. Five full pulses give 5 with the rising code, 10 with both, and 4 pulses give 4 with the falling code.
- R4: A match event is a TC advance moment (tick) that occurs while TC equals a match register (channel i at address 8+i). On a match event with reset-on-match, TC becomes 0 instead of the match value plus one, so TC shows the match value for one tick.
- R5: On a match event with stop-on-match, TC keeps its value and the enable bit clears. The stop takes priority over both a reset-on-match and a software write of enable in the same cycle.
- R6: Channel configuration register at address 6 holds 8 bits per channel, channel i at bits 8i+7:8i: bit0 interrupt, bit1 reset, bit2 stop, bits 4:3 pin action, bit5 PWM. A match event sets flag bit i only when that channel's interrupt bit is 1. A channel with interrupt enabled but stop disabled keeps counting.
- R7: On a match event of a non-PWM channel, its pin `match_out[i]` follows the action code: 00 unchanged, 01 driven 0, 10 driven 1, 11 inverted.
- R8: A channel 0 to 2 with its PWM bit set updates its pin every clock. The pin goes to 1 one clock after TC equals its match value, and to 0 one clock after TC is 0 (the match takes precedence). A match value of 0 gives a constant 1. A value above the period gives a constant 0.
- R9: On each synchronized `cap_in` edge selected by the capture code (same encoding as R3), TC is copied into the capture register (address 5). Flag bit 4 is set only if the capture interrupt enable is 1.
- R10: Flag register at address 4 holds bits 3:0 for the match channels and bit 4 for capture. The flags are sticky. Writing 1 to a bit clears it, and a new set in the same cycle wins over the clear. `irq` is 1 exactly when any flag is 1.
- R11: After reset every register reads 0, and all match pins and `irq` are 0.
- R12: From one clock to the next, TC either holds, increases by exactly one, or becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (4) | Register word address |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data for `bus_addr`, combinational |
| cap_in | input | 1 | Asynchronous capture trigger |
| cnt_in | input | 1 | Asynchronous count input for counter mode |
| match_out | output | NCH (4) | Match / PWM output pins |
| irq | output | 1 | Level interrupt, OR of all flags |

## Verification
The bound checker watches the invariants on every cycle. TC may only hold, step by one or return to zero. The synchronous reset must clear both counters. A stop-on-match must freeze TC and drop the enable bit. Flags may only fall through a write-one-to-clear. A PWM channel with match value 0 must stay high once TC has passed zero. The bench scenarios cover the behaviour that needs a known history: exact prescaled tick counts, the moment of wrap after reset-on-match, the order of pin actions over several periods, the PWM duty pattern against the live counter, and capture and counting under each edge code.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } pin_act_e;

  // per-channel configuration lane, LSB first: irq, rst, stop, act, pwm
  typedef struct packed {
    logic     pwm;
    pin_act_e act;
    logic     stop;
    logic     rst;
    logic     irq;
  } ch_cfg_t;

  localparam int CFG_LANE = 8;
  localparam int CFG_BITS = $bits(ch_cfg_t);

  localparam int A_CTRL = 0;
  localparam int A_PRE  = 1;
  localparam int A_TC   = 2;
  localparam int A_PC   = 3;
  localparam int A_FLAG = 4;
  localparam int A_CAP  = 5;
  localparam int A_CFG  = 6;
  localparam int A_MR0  = 8;
endpackage

// File: rtl/mct_edge_sync.sv
`timescale 1ns/1ps
// Synchronizes an asynchronous pin and flags selected edges (sel[0] rising, sel[1] falling).
module mct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       pulse
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse = (sel[0] &  sync_q[STAGES-1] & ~last_q)
               | (sel[1] & ~sync_q[STAGES-1] &  last_q);
endmodule

// File: rtl/mct_match_ch.sv
`timescale 1ns/1ps
// One match channel: equality compare and output pin (action or single-edge PWM).
module mct_match_ch
  import mct_pkg::*;
#(
  parameter int W      = 32,
  parameter bit PWM_OK = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] tc,
  input  logic [W-1:0] mr,
  input  pin_act_e     act,
  input  logic         pwm_en,
  output logic         hit,
  output logic         pin
);
  logic act_d, pin_d, pwm_on;

  assign hit    = (tc == mr);
  assign pwm_on = PWM_OK && pwm_en;

  always_comb begin
    unique case (act)
      ACT_CLR: act_d = 1'b0;
      ACT_SET: act_d = 1'b1;
      ACT_TGL: act_d = ~pin;
      default: act_d = pin;
    endcase
  end

  always_comb begin
    if (pwm_on)           pin_d = hit ? 1'b1 : ((tc == '0) ? 1'b0 : pin);
    else if (tick && hit) pin_d = act_d;
    else                  pin_d = pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_d;
  end
endmodule

// File: rtl/mct_timer.sv
`timescale 1ns/1ps
module mct_timer
  import mct_pkg::*;
#(
  parameter int W           = 32,
  parameter int NCH         = 4,
  parameter int AW          = 4,
  parameter int PWM_CH      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  input  logic           cap_in,
  input  logic           cnt_in,
  output logic [NCH-1:0] match_out,
  output logic           irq
);
  localparam int FW      = NCH + 1;
  localparam int CAP_BIT = NCH;

  logic                  ctrl_en, ctrl_srst, ctrl_cnt_mode, ctrl_cap_irq;
  logic [1:0]            cnt_edge, cap_edge;
  logic [W-1:0]          pr_q, pc_q, tc_q, cap_q;
  logic [FW-1:0]         flags_q, flag_set, flag_clr;
  ch_cfg_t [NCH-1:0]     cfg_q;
  logic [NCH-1:0][W-1:0] mr_q;
  logic [NCH-1:0]        hit, stop_m, rst_m, irq_m, pwm_req, wr_mr;
  logic                  cnt_pulse, cap_pulse, inc, tick, stop_hit, rst_hit;
  logic                  wr_ctrl, wr_pre, wr_flag, wr_cfg;
  logic [7:0]            ctrl_rd;
  logic [W-1:0]          cfg_rd;

  // ---------------- input edge detection ----------------
  mct_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_in), .sel(cnt_edge), .pulse(cnt_pulse));
  mct_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .sel(cap_edge), .pulse(cap_pulse));

  // ---------------- match channels ----------------
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign stop_m[i]  = cfg_q[i].stop;
    assign rst_m[i]   = cfg_q[i].rst;
    assign irq_m[i]   = cfg_q[i].irq;
    assign pwm_req[i] = cfg_q[i].pwm;
    assign wr_mr[i]   = bus_we && (bus_addr == AW'(A_MR0 + i));
    mct_match_ch #(.W(W), .PWM_OK(i < PWM_CH)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tc(tc_q), .mr(mr_q[i]),
      .act(cfg_q[i].act), .pwm_en(pwm_req[i]), .hit(hit[i]), .pin(match_out[i]));
  end

  // ---------------- counting ----------------
  assign inc      = ctrl_en && !ctrl_srst && (ctrl_cnt_mode ? cnt_pulse : 1'b1);
  assign tick     = inc && (pc_q >= pr_q);
  assign stop_hit = |(hit & stop_m);
  assign rst_hit  = |(hit & rst_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (ctrl_srst) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (inc) begin
      pc_q <= tick ? '0 : pc_q + 1'b1;
      if (tick && !stop_hit) tc_q <= rst_hit ? '0 : tc_q + 1'b1;
    end
  end

  // ---------------- register writes ----------------
  assign wr_ctrl  = bus_we && (bus_addr == AW'(A_CTRL));
  assign wr_pre   = bus_we && (bus_addr == AW'(A_PRE));
  assign wr_flag  = bus_we && (bus_addr == AW'(A_FLAG));
  assign wr_cfg   = bus_we && (bus_addr == AW'(A_CFG));
  assign flag_clr = wr_flag ? bus_wdata[FW-1:0] : '0;
  assign flag_set = {cap_pulse & ctrl_cap_irq, tick ? (hit & irq_m) : {NCH{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ctrl_cap_irq, cap_edge, cnt_edge, ctrl_cnt_mode, ctrl_srst, ctrl_en} <= '0;
      pr_q    <= '0;
      cap_q   <= '0;
      flags_q <= '0;
      cfg_q   <= '0;
      mr_q    <= '0;
    end else begin
      if (wr_ctrl)
        {ctrl_cap_irq, cap_edge, cnt_edge, ctrl_cnt_mode, ctrl_srst, ctrl_en} <= bus_wdata[7:0];
      if (tick && stop_hit) ctrl_en <= 1'b0;
      if (wr_pre) pr_q <= bus_wdata;
      if (cap_pulse) cap_q <= tc_q;
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      for (int i = 0; i < NCH; i++) begin
        if (wr_cfg)   cfg_q[i] <= bus_wdata[i*CFG_LANE +: CFG_BITS];
        if (wr_mr[i]) mr_q[i]  <= bus_wdata;
      end
    end
  end

  assign irq = |flags_q;

  // ---------------- register reads ----------------
  assign ctrl_rd = {ctrl_cap_irq, cap_edge, cnt_edge, ctrl_cnt_mode, ctrl_srst, ctrl_en};

  always_comb begin
    cfg_rd = '0;
    for (int i = 0; i < NCH; i++) cfg_rd[i*CFG_LANE +: CFG_BITS] = cfg_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == AW'(A_CTRL)) bus_rdata = W'(ctrl_rd);
    else if (bus_addr == AW'(A_PRE))  bus_rdata = pr_q;
    else if (bus_addr == AW'(A_TC))   bus_rdata = tc_q;
    else if (bus_addr == AW'(A_PC))   bus_rdata = pc_q;
    else if (bus_addr == AW'(A_FLAG)) bus_rdata = W'(flags_q);
    else if (bus_addr == AW'(A_CAP))  bus_rdata = cap_q;
    else if (bus_addr == AW'(A_CFG))  bus_rdata = cfg_rd;
    else begin
      for (int i = 0; i < NCH; i++)
        if (bus_addr == AW'(A_MR0 + i)) bus_rdata = mr_q[i];
    end
  end
endmodule

// File: rtl/mct_timer_chk.sv
`timescale 1ns/1ps
module mct_timer_chk
  import mct_pkg::*;
#(
  parameter int W      = 32,
  parameter int NCH    = 4,
  parameter int AW     = 4,
  parameter int PWM_CH = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_we,
  input logic [AW-1:0]            bus_addr,
  input logic [NCH:0]             flag_wdata,
  input logic [W-1:0]             tc,
  input logic [W-1:0]             pc,
  input logic                     srst,
  input logic                     en,
  input logic                     tick,
  input logic                     stop_hit,
  input logic [NCH:0]             flags,
  input logic [PWM_CH-1:0]        pwm_req,
  input logic [PWM_CH-1:0][W-1:0] mr,
  input logic [PWM_CH-1:0]        pins
);
  logic [NCH:0] clr_mask;
  assign clr_mask = (bus_we && bus_addr == AW'(A_FLAG)) ? flag_wdata : '0;

  // R12: counter holds, steps by one, or returns to zero
  p_tc_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tc == $past(tc)) || (tc == W'($past(tc) + 1'b1)) || (tc == '0));

  // R2: synchronous reset clears both counters
  p_srst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (tc == '0) && (pc == '0));

  // R5: stop-on-match freezes the counter and drops enable
  p_stop_clears_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stop_hit) |=> (!en && $stable(tc)));

  // R10: flags only fall through write-one-to-clear
  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask)));

  // R8: PWM channel with match value zero stays high once the counter passed zero
  for (genvar c = 0; c < PWM_CH; c++) begin : g_pwm_chk
    p_pwm_zero_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pwm_req[c] && mr[c] == '0 && tc == '0) |-> pins[c]);
  end
endmodule

bind mct_timer mct_timer_chk #(.W(W), .NCH(NCH), .AW(AW), .PWM_CH(PWM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .flag_wdata(bus_wdata[NCH:0]), .tc(tc_q), .pc(pc_q), .srst(ctrl_srst), .en(ctrl_en),
  .tick(tick), .stop_hit(stop_hit), .flags(flags_q), .pwm_req(pwm_req[PWM_CH-1:0]),
  .mr(mr_q[PWM_CH-1:0]), .pins(match_out[PWM_CH-1:0]));

// File: tb/mct_timer_tb.sv
`timescale 1ns/1ps
module mct_timer_tb;
  localparam int W = 32, NCH = 4, AW = 4;
  localparam logic [3:0] A_CTRL = 0, A_PRE = 1, A_TC = 2, A_PC = 3, A_FLAG = 4,
                         A_CAP = 5, A_CFG = 6, A_MR0 = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, cap_in = 1'b0, cnt_in = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] match_out;
  logic irq;

  always #2.5 clk = ~clk;

  mct_timer u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .cnt_in(cnt_in),
    .match_out(match_out), .irq(irq));

  // ---------------- scoreboard ----------------
  typedef struct { int kind; logic [W-1:0] exp; string tag; } item_t;
  item_t sb_q[$];
  event  sb_ev;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  initial forever begin
    @(sb_ev);
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [W-1:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = W'(match_out);
        default: act = W'(irq);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push_exp(input int kind, input logic [W-1:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> sb_ev;
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [W-1:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    push_exp(0, e, tag);
    #2;
  endtask

  task automatic chk_pins(input logic [NCH-1:0] e, input string tag);
    @(negedge clk);
    push_exp(1, W'(e), tag);
    #2;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    push_exp(2, W'(e), tag);
    #2;
  endtask

  // exactly k counting clocks with enable set
  task automatic run_for(input logic [7:0] ctrl, input int k);
    wr(A_CTRL, W'(ctrl | 8'h01));
    repeat (k - 1) @(posedge clk);
    wr(A_CTRL, W'(ctrl));
  endtask

  task automatic sreset();
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cnt_in = 1'b1;
      repeat (3) @(negedge clk);
      cnt_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state
    chk_rd(A_CTRL, 0, "R11 ctrl");
    chk_rd(A_PRE,  0, "R11 prescale");
    chk_rd(A_TC,   0, "R11 tc");
    chk_rd(A_FLAG, 0, "R11 flags");
    chk_rd(A_CAP,  0, "R11 capture");
    chk_pins(4'b0000, "R11 pins");
    chk_irq(1'b0, "R11 irq");

    // R1 prescaler in timer mode
    wr(A_PRE, 3);
    run_for(8'h00, 20);
    chk_rd(A_TC, 5, "R1 tc after 20 clocks");
    chk_rd(A_PC, 0, "R1 pc after 20 clocks");
    run_for(8'h00, 2);
    chk_rd(A_TC, 5, "R1 tc after 22 clocks");
    chk_rd(A_PC, 2, "R1 pc after 22 clocks");
    // R2 disabled counter holds, then synchronous reset clears
    repeat (10) @(posedge clk);
    chk_rd(A_TC, 5, "R2 hold while disabled");
    wr(A_CTRL, 32'h3);
    repeat (3) @(posedge clk);
    chk_rd(A_TC, 0, "R2 tc in sync reset");
    chk_rd(A_PC, 0, "R2 pc in sync reset");
    wr(A_CTRL, 0);
    wr(A_PRE, 0);

    // R5 / R6 stop-on-match with interrupt
    wr(A_MR0, 10);
    wr(A_CFG, 32'h5);
    wr(A_CTRL, 32'h1);
    repeat (30) @(posedge clk);
    chk_rd(A_TC, 10, "R5 tc frozen at match");
    chk_rd(A_CTRL, 0, "R5 enable cleared");
    chk_rd(A_FLAG, 1, "R6 match flag set");
    chk_irq(1'b1, "R10 irq raised");
    wr(A_FLAG, 1);
    chk_rd(A_FLAG, 0, "R10 flag cleared by write");
    chk_irq(1'b0, "R10 irq dropped");
    wr(A_CFG, 32'h1);
    run_for(8'h00, 3);
    chk_rd(A_TC, 13, "R6 irq-only match keeps counting");
    chk_rd(A_FLAG, 1, "R6 irq-only flag");
    wr(A_FLAG, 1);

    // R4 / R7 reset-on-match and pin actions
    sreset();
    wr(A_MR0 + 1, 4);
    wr(A_MR0 + 2, 2);
    wr(A_CFG, 32'h0010_1A00);     // ch1 rst+toggle, ch2 set
    run_for(8'h00, 4);
    chk_rd(A_TC, 4, "R4 tc shows match value");
    chk_pins(4'b0100, "R7 set action");
    chk_rd(A_FLAG, 0, "R6 no flag without irq bit");
    run_for(8'h00, 3);
    chk_rd(A_TC, 2, "R4 wrap after match");
    chk_pins(4'b0110, "R7 toggle action");
    wr(A_CFG, 32'h0008_0200);     // ch1 rst+none, ch2 clear
    run_for(8'h00, 5);
    chk_rd(A_TC, 2, "R4 second period");
    chk_pins(4'b0010, "R7 clear and none actions");

    // R8 PWM: ch3 period 9, ch0 duty at 3, ch1 value 0, ch2 beyond period
    sreset();
    wr(A_MR0 + 0, 3);
    wr(A_MR0 + 1, 0);
    wr(A_MR0 + 2, 20);
    wr(A_MR0 + 3, 9);
    wr(A_CFG, 32'h0220_2020);
    wr(A_CTRL, 32'h1);
    repeat (15) @(posedge clk);
    for (int s = 0; s < 20; s++) begin
      logic [W-1:0] t;
      @(negedge clk);
      bus_addr = A_TC;
      #1 t = bus_rdata;
      push_exp(1, W'({2'b00, 1'b1, (t >= 4 || t == 0)}), "R8 pwm pattern");
    end
    wr(A_CTRL, 0);

    // R9 capture
    sreset();
    wr(A_CFG, 0);
    run_for(8'h00, 7);
    wr(A_CTRL, 32'hA0);           // rising, irq enabled
    @(negedge clk) cap_in = 1'b1;
    settle();
    chk_rd(A_CAP, 7, "R9 capture on rising edge");
    chk_rd(A_FLAG, 32'h10, "R9 capture flag");
    chk_irq(1'b1, "R10 irq from capture");
    wr(A_FLAG, 32'h10);
    run_for(8'hA0, 5);
    @(negedge clk) cap_in = 1'b0;
    settle();
    chk_rd(A_CAP, 7, "R9 falling edge ignored in rising mode");
    chk_rd(A_FLAG, 0, "R9 no flag on ignored edge");
    wr(A_CTRL, 32'hE0);           // both edges
    @(negedge clk) cap_in = 1'b1;
    settle();
    chk_rd(A_CAP, 12, "R9 capture in both-edge mode");
    wr(A_FLAG, 32'h10);
    run_for(8'h60, 3);            // both edges, no irq
    @(negedge clk) cap_in = 1'b0;
    settle();
    chk_rd(A_CAP, 15, "R9 capture on falling edge");
    chk_rd(A_FLAG, 0, "R9 no flag with irq disabled");

    // R3 counter mode
    sreset();
    wr(A_CTRL, 32'h0D);           // counter, rising
    pulses(5);
    chk_rd(A_TC, 5, "R3 rising edges counted");
    sreset();
    wr(A_CTRL, 32'h1D);           // counter, both
    pulses(5);
    chk_rd(A_TC, 10, "R3 both edges counted");
    sreset();
    wr(A_PRE, 1);
    wr(A_CTRL, 32'h0D);
    pulses(6);
    chk_rd(A_TC, 3, "R1 prescaler in counter mode");
    chk_rd(A_PC, 0, "R1 pc in counter mode");
    sreset();
    wr(A_PRE, 0);
    wr(A_CTRL, 32'h15);           // counter, falling
    pulses(4);
    chk_rd(A_TC, 4, "R3 falling edges counted");

    #20;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule